// File: doc/BRIEF.md
# Configuration register bank with strap overrides

This block is the control and status register bank of a multi-lane USB/DisplayPort signal path. A host agent reaches it through a plain register port: an 8-bit offset, 8-bit write data, a write strobe, and combinational read data. The bank holds the path's operating mode, cable orientation, channel swap, per-port equalization, gain selection, DisplayPort lane control and USB receiver settings. Every effective setting leaves the block as a decoded output port for the analog and datapath logic around it.

Strap pins are latched once, on the first clock after reset is released. Equalization and gain fields show those latched strap codes until software sets the matching override bit. From then on the fields hold whatever software writes. A link monitor outside the block reports the snooped lane count and power state. That status decides which DisplayPort lanes are enabled, unless software switches the monitor out and drives each lane directly. The bank has two self-clearing reset commands. One restores every register to its default. The other clears only the snooped status.

Top module: `cfg_regbank`

## Requirements
- R1: After reset the readback is 0x01 at 0x0A (mode 1 = USB only), 0x04 at 0x22 (receiver-detect interval code 1 in bits [3:2]), and 0x23 at 0x23 (loss hysteresis code 4 in bits [5:3], loss threshold code 3 in bits [2:0]). Offsets 0x0B, 0x12, 0x13 and 0x1B read 0x00.
- R2: Only 0x0A, 0x0B, 0x0C, 0x10, 0x11, 0x12, 0x13, 0x1B and 0x20–0x23 are decoded. Any other offset reads 0x00, and a write to it changes no register.
- R3: Reserved bits read 0: 0x0A[7:6], 0x0B[7:4], 0x0C[7], 0x12[7], 0x13[6], 0x1B[5:0] and 0x23[7:6]. Writing all ones gives 0x3F, 0x0F, 0x7F (at 0x0C), 0xBF and 0x3F respectively.
- R4: The strap inputs are latched on the first clock edge after reset release. Later changes on the strap pins have no effect on readback or outputs.
- R5: While the equalization override bit (0x0A bit 4) is 0, each nibble of 0x10/0x11 reads the upstream strap code and each nibble of 0x20/0x21 reads the downstream strap code. Writes to those four offsets are dropped.
- R6: While 0x0A bit 4 is 1, offsets 0x10/0x11/0x20/0x21 store the written bytes. eq_ufp_o is {0x10, 0x11} and eq_dfp_o is {0x20, 0x21}.
- R7: Offset 0x0C has gain override in bit 6, gain select in bits [5:2] and direction mode in bits [1:0]. With the override at 0, bits [5:2] read {strap_gain_hi, strap_gain_lo}. The stored gain field is written only when the same write carries bit 6 = 1.
- R8: A snoop_wr pulse loads snoop_power and snoop_lanes into offset 0x12 as {0, power[1:0], lanes[4:0]}. Software writes to 0x12 are ignored.
- R9: With the snoop-disable bit (0x13 bit 7) at 0, lane counts 1, 2 and 4 enable lanes 0, 0–1 and 0–3. Any other count enables none. Power state 2 turns every lane off, and the lane-disable bits have no effect.
- R10: With 0x13 bit 7 at 1, DisplayPort lane i is enabled exactly when 0x13 bit i is 0. 0x13 bits [5:4] drive aux_route_o.
- R11: Writing 1 to 0x1B bit 7 makes that bit read 1 for one clock. On the next edge every register returns to its R1 value and the bit reads 0.
- R12: Writing 1 to 0x1B bit 6 makes that bit read 1 for one clock. On the next edge only the 0x12 status is cleared.
- R13: A write to 0x0A that moves mode bit 1 from 1 to 0 clears the 0x12 status on that same edge.
- R14: 0x22 bit 7 shows compliance_in delayed by one clock and ignores writes. Bits [6:0] are read/write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| strap_eq_up | input | 4 | Upstream equalization strap code |
| strap_eq_dn | input | 4 | Downstream equalization strap code |
| strap_gain_hi | input | 2 | Upper gain strap (0 low, 1 resistor, 2 float, 3 high) |
| strap_gain_lo | input | 2 | Lower gain strap, same coding |
| snoop_wr | input | 1 | Link monitor status update strobe |
| snoop_power | input | 2 | Snooped sink power state |
| snoop_lanes | input | 5 | Snooped lane count |
| compliance_in | input | 1 | Compliance-mode indication from the USB state machine |
| mode_o | output | 2 | Operating mode |
| flip_o | output | 1 | Orientation flip |
| swap_all_o | output | 1 | Global direction swap |
| hpd_force_o | output | 1 | Hot-plug input forced high |
| lane_swap_o | output | 4 | Per-channel direction swap |
| dir_mode_o | output | 2 | Source/sink and alt-mode selection |
| gain_sel_o | output | 4 | Effective gain/linearity select |
| eq_ufp_o | output | 16 | Effective upstream equalization, four nibbles |
| eq_dfp_o | output | 16 | Effective downstream equalization, four nibbles |
| dp_lane_en_o | output | 4 | DisplayPort lane enables |
| aux_route_o | output | 2 | Auxiliary channel routing override |
| usb_ctl_o | output | 7 | USB receiver controls (0x22 bits [6:0]) |
| los_hyst_o | output | 3 | Loss-of-signal hysteresis code |
| los_vth_o | output | 3 | Loss-of-signal threshold code |

## Verification
The assertions watch, on every cycle, that each soft-reset bit stays high for a single clock and that a full reset lands the defaults on the next edge. They also check that a link reset or a mode drop clears the snooped status, and that writes to undecoded offsets or to locked equalization registers leave the outputs unchanged. Only the bench scenarios can show the actual values: strap codes packed into the read fields, the lane masks decoded from counts and power states, reserved-bit masking, and the hand-off from strap to software value when an override bit is toggled.

// File: rtl/cfg_regbank_pkg.sv
// Package: shared widths, register offsets, the register image type and
// its default value, plus the lane-count decode used by the lane logic.
package cfg_regbank_pkg;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int EQ_W       = 4;
    localparam int EQ_PORTS   = 4;
    localparam int EQV_W      = EQ_W * EQ_PORTS;
    localparam int DP_LANES   = 4;
    localparam int CNT_W      = 5;
    localparam int PWR_W      = 2;
    localparam int USB_W      = 7;
    localparam int LOS_W      = 3;
    localparam int STRAP_W    = 3 * EQ_W;

    localparam logic [PWR_W-1:0] PWR_DOWN = 2'd2;

    localparam logic [ADDR_W-1:0] OFS_CORE   = 8'h0A;
    localparam logic [ADDR_W-1:0] OFS_CHSWAP = 8'h0B;
    localparam logic [ADDR_W-1:0] OFS_GAIN   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_UP_B   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_UP_A   = 8'h11;
    localparam logic [ADDR_W-1:0] OFS_LINK   = 8'h12;
    localparam logic [ADDR_W-1:0] OFS_LANES  = 8'h13;
    localparam logic [ADDR_W-1:0] OFS_SRST   = 8'h1B;
    localparam logic [ADDR_W-1:0] OFS_DN_B   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DN_A   = 8'h21;
    localparam logic [ADDR_W-1:0] OFS_USB    = 8'h22;
    localparam logic [ADDR_W-1:0] OFS_LOS    = 8'h23;

    typedef struct packed {
        logic [1:0]        mode;
        logic              swap_all;
        logic              eq_ovr;
        logic              hpd_force;
        logic              flip;
        logic [DP_LANES-1:0] lane_swap;
        logic              gain_ovr;
        logic [EQ_W-1:0]   gain_sw;
        logic [1:0]        dir_mode;
        logic [REG_W-1:0]  up_b;
        logic [REG_W-1:0]  up_a;
        logic [REG_W-1:0]  dn_b;
        logic [REG_W-1:0]  dn_a;
        logic              snoop_off;
        logic [1:0]        aux_route;
        logic [DP_LANES-1:0] lane_dis;
        logic [USB_W-1:0]  usb_ctl;
        logic [LOS_W-1:0]  los_hyst;
        logic [LOS_W-1:0]  los_vth;
    } cfg_regs_t;

    localparam cfg_regs_t CFG_DEFAULTS = '{
        mode: 2'd1, swap_all: 1'b0, eq_ovr: 1'b0, hpd_force: 1'b0, flip: 1'b0,
        lane_swap: '0, gain_ovr: 1'b0, gain_sw: '0, dir_mode: 2'd0,
        up_b: '0, up_a: '0, dn_b: '0, dn_a: '0,
        snoop_off: 1'b0, aux_route: 2'd0, lane_dis: '0,
        usb_ctl: 7'h04, los_hyst: 3'd4, los_vth: 3'd3
    };

    // Lane mask for a snooped count: only 1, 2 and 4 lanes are legal.
    function automatic logic [DP_LANES-1:0] lanes_for_count(input logic [CNT_W-1:0] cnt);
        logic [DP_LANES-1:0] m;
        m = '0;
        if (cnt == 5'd1 || cnt == 5'd2 || cnt == 5'd4) begin
            for (int i = 0; i < DP_LANES; i++) begin
                m[i] = (i < int'(cnt));
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/cfg_strap_latch.sv
// Strap latch: captures the strap pin vector once, on the first clock edge
// after reset release, and holds it until the next hardware reset.
// Assumes the strap pins are static around reset release.
module cfg_strap_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strap_in,
    output logic [W-1:0] strap_q,
    output logic         done
);
    // One-shot capture, guarded by the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= '0;
            done    <= 1'b0;
        end else if (!done) begin
            strap_q <= strap_in;
            done    <= 1'b1;
        end
    end
endmodule

// File: rtl/cfg_reg_store.sv
// Register storage: software-writable fields, self-clearing reset pulses,
// snooped link status and the compliance status flop.
// Assumes at most one write per cycle; a pending full reset wins over writes.
module cfg_reg_store
    import cfg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              snoop_wr,
    input  logic [PWR_W-1:0]  snoop_power,
    input  logic [CNT_W-1:0]  snoop_lanes,
    input  logic              compliance_in,
    output cfg_regs_t         regs,
    output logic [PWR_W-1:0]  st_power,
    output logic [CNT_W-1:0]  st_lanes,
    output logic              cm_q,
    output logic              pulse_full,
    output logic              pulse_link
);
    logic srst_wr;
    logic mode_drop;

    assign srst_wr   = wr && (addr == OFS_SRST);
    assign mode_drop = wr && (addr == OFS_CORE) && regs.mode[1] && !wdata[1] && !pulse_full;

    // Software-owned fields and the two self-clearing command bits.
    always_ff @(posedge clk) begin
        if (!rst_n || pulse_full) begin
            regs       <= CFG_DEFAULTS;
            pulse_full <= 1'b0;
            pulse_link <= 1'b0;
        end else begin
            pulse_full <= srst_wr && wdata[7];
            pulse_link <= srst_wr && wdata[6];
            if (wr) begin
                case (addr)
                    OFS_CORE: begin
                        regs.swap_all  <= wdata[5];
                        regs.eq_ovr    <= wdata[4];
                        regs.hpd_force <= wdata[3];
                        regs.flip      <= wdata[2];
                        regs.mode      <= wdata[1:0];
                    end
                    OFS_CHSWAP: regs.lane_swap <= wdata[DP_LANES-1:0];
                    OFS_GAIN: begin
                        regs.gain_ovr <= wdata[6];
                        if (wdata[6]) regs.gain_sw <= wdata[5:2];
                        regs.dir_mode <= wdata[1:0];
                    end
                    OFS_UP_B: if (regs.eq_ovr) regs.up_b <= wdata;
                    OFS_UP_A: if (regs.eq_ovr) regs.up_a <= wdata;
                    OFS_DN_B: if (regs.eq_ovr) regs.dn_b <= wdata;
                    OFS_DN_A: if (regs.eq_ovr) regs.dn_a <= wdata;
                    OFS_LANES: begin
                        regs.snoop_off <= wdata[7];
                        regs.aux_route <= wdata[5:4];
                        regs.lane_dis  <= wdata[DP_LANES-1:0];
                    end
                    OFS_USB: regs.usb_ctl <= wdata[USB_W-1:0];
                    OFS_LOS: begin
                        regs.los_hyst <= wdata[5:3];
                        regs.los_vth  <= wdata[2:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Snooped link status: hardware-loaded, cleared by either reset command or a mode drop.
    always_ff @(posedge clk) begin
        if (!rst_n || pulse_full || pulse_link || mode_drop) begin
            st_power <= '0;
            st_lanes <= '0;
        end else if (snoop_wr) begin
            st_power <= snoop_power;
            st_lanes <= snoop_lanes;
        end
    end

    // Compliance status follows its input one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) cm_q <= 1'b0;
        else        cm_q <= compliance_in;
    end
endmodule

// File: rtl/cfg_decode.sv
// Effective-setting decode: chooses strap or software values for the
// equalization and gain fields and derives the DisplayPort lane enables.
// Pure combinational; assumes the strap vector is already latched.
module cfg_decode
    import cfg_regbank_pkg::*;
(
    input  logic                eq_ovr,
    input  logic [EQV_W-1:0]    up_sw,
    input  logic [EQV_W-1:0]    dn_sw,
    input  logic [EQ_W-1:0]     strap_up,
    input  logic [EQ_W-1:0]     strap_dn,
    input  logic                gain_ovr,
    input  logic [EQ_W-1:0]     gain_sw,
    input  logic [EQ_W-1:0]     strap_gain,
    input  logic                snoop_off,
    input  logic [DP_LANES-1:0] lane_dis,
    input  logic [PWR_W-1:0]    st_power,
    input  logic [CNT_W-1:0]    st_lanes,
    output logic [EQV_W-1:0]    eq_up_eff,
    output logic [EQV_W-1:0]    eq_dn_eff,
    output logic [EQ_W-1:0]     gain_eff,
    output logic [DP_LANES-1:0] lane_en
);
    logic [DP_LANES-1:0] snoop_mask;

    // Replicate the strap code into every port nibble unless software owns the field.
    for (genvar p = 0; p < EQ_PORTS; p++) begin : g_eq
        assign eq_up_eff[p*EQ_W +: EQ_W] = eq_ovr ? up_sw[p*EQ_W +: EQ_W] : strap_up;
        assign eq_dn_eff[p*EQ_W +: EQ_W] = eq_ovr ? dn_sw[p*EQ_W +: EQ_W] : strap_dn;
    end

    assign gain_eff = gain_ovr ? gain_sw : strap_gain;

    // Lane enables from snooped status or from the software disable bits.
    always_comb begin
        snoop_mask = (st_power == PWR_DOWN) ? '0 : lanes_for_count(st_lanes);
        lane_en    = snoop_off ? ~lane_dis : snoop_mask;
    end
endmodule

// File: rtl/cfg_read_mux.sv
// Read multiplexer: assembles the byte for the addressed offset, forcing
// reserved bits and undecoded offsets to zero. Combinational.
module cfg_read_mux
    import cfg_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          mode,
    input  logic                swap_all,
    input  logic                eq_ovr,
    input  logic                hpd_force,
    input  logic                flip,
    input  logic [DP_LANES-1:0] lane_swap,
    input  logic                gain_ovr,
    input  logic [EQ_W-1:0]     gain_eff,
    input  logic [1:0]          dir_mode,
    input  logic [EQV_W-1:0]    eq_up_eff,
    input  logic [EQV_W-1:0]    eq_dn_eff,
    input  logic [PWR_W-1:0]    st_power,
    input  logic [CNT_W-1:0]    st_lanes,
    input  logic                snoop_off,
    input  logic [1:0]          aux_route,
    input  logic [DP_LANES-1:0] lane_dis,
    input  logic                pulse_full,
    input  logic                pulse_link,
    input  logic                cm_q,
    input  logic [USB_W-1:0]    usb_ctl,
    input  logic [LOS_W-1:0]    los_hyst,
    input  logic [LOS_W-1:0]    los_vth,
    output logic [REG_W-1:0]    rdata
);
    // Offset decode with reserved-bit masking.
    always_comb begin
        case (addr)
            OFS_CORE:   rdata = {2'b00, swap_all, eq_ovr, hpd_force, flip, mode};
            OFS_CHSWAP: rdata = {4'b0000, lane_swap};
            OFS_GAIN:   rdata = {1'b0, gain_ovr, gain_eff, dir_mode};
            OFS_UP_B:   rdata = eq_up_eff[EQV_W-1 -: REG_W];
            OFS_UP_A:   rdata = eq_up_eff[REG_W-1:0];
            OFS_LINK:   rdata = {1'b0, st_power, st_lanes};
            OFS_LANES:  rdata = {snoop_off, 1'b0, aux_route, lane_dis};
            OFS_SRST:   rdata = {pulse_full, pulse_link, 6'b000000};
            OFS_DN_B:   rdata = eq_dn_eff[EQV_W-1 -: REG_W];
            OFS_DN_A:   rdata = eq_dn_eff[REG_W-1:0];
            OFS_USB:    rdata = {cm_q, usb_ctl};
            OFS_LOS:    rdata = {2'b00, los_hyst, los_vth};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_regbank.sv
// Top: configuration register bank. Wires the strap latch, storage, decode
// and read mux, and drives the effective settings out as ports.
// Synchronous active-low reset; reads are combinational from reg_addr.
module cfg_regbank
    import cfg_regbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic                reg_wr,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [EQ_W-1:0]     strap_eq_up,
    input  logic [EQ_W-1:0]     strap_eq_dn,
    input  logic [1:0]          strap_gain_hi,
    input  logic [1:0]          strap_gain_lo,
    input  logic                snoop_wr,
    input  logic [PWR_W-1:0]    snoop_power,
    input  logic [CNT_W-1:0]    snoop_lanes,
    input  logic                compliance_in,
    output logic [1:0]          mode_o,
    output logic                flip_o,
    output logic                swap_all_o,
    output logic                hpd_force_o,
    output logic [DP_LANES-1:0] lane_swap_o,
    output logic [1:0]          dir_mode_o,
    output logic [EQ_W-1:0]     gain_sel_o,
    output logic [EQV_W-1:0]    eq_ufp_o,
    output logic [EQV_W-1:0]    eq_dfp_o,
    output logic [DP_LANES-1:0] dp_lane_en_o,
    output logic [1:0]          aux_route_o,
    output logic [USB_W-1:0]    usb_ctl_o,
    output logic [LOS_W-1:0]    los_hyst_o,
    output logic [LOS_W-1:0]    los_vth_o
);
    cfg_regs_t          regs;
    logic [STRAP_W-1:0] strap_q;
    logic               strap_done;
    logic [PWR_W-1:0]   st_power;
    logic [CNT_W-1:0]   st_lanes;
    logic               cm_q;
    logic               pulse_full;
    logic               pulse_link;
    logic               eq_ovr;
    logic [EQV_W-1:0]   eq_up_eff;
    logic [EQV_W-1:0]   eq_dn_eff;
    logic [EQ_W-1:0]    gain_eff;

    assign eq_ovr = regs.eq_ovr;

    cfg_strap_latch #(.W(STRAP_W)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in ({strap_gain_hi, strap_gain_lo, strap_eq_dn, strap_eq_up}),
        .strap_q  (strap_q),
        .done     (strap_done)
    );

    cfg_reg_store u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (reg_wr),
        .addr          (reg_addr),
        .wdata         (reg_wdata),
        .snoop_wr      (snoop_wr),
        .snoop_power   (snoop_power),
        .snoop_lanes   (snoop_lanes),
        .compliance_in (compliance_in),
        .regs          (regs),
        .st_power      (st_power),
        .st_lanes      (st_lanes),
        .cm_q          (cm_q),
        .pulse_full    (pulse_full),
        .pulse_link    (pulse_link)
    );

    cfg_decode u_decode (
        .eq_ovr     (regs.eq_ovr),
        .up_sw      ({regs.up_b, regs.up_a}),
        .dn_sw      ({regs.dn_b, regs.dn_a}),
        .strap_up   (strap_q[EQ_W-1:0]),
        .strap_dn   (strap_q[2*EQ_W-1:EQ_W]),
        .gain_ovr   (regs.gain_ovr),
        .gain_sw    (regs.gain_sw),
        .strap_gain (strap_q[STRAP_W-1:2*EQ_W]),
        .snoop_off  (regs.snoop_off),
        .lane_dis   (regs.lane_dis),
        .st_power   (st_power),
        .st_lanes   (st_lanes),
        .eq_up_eff  (eq_up_eff),
        .eq_dn_eff  (eq_dn_eff),
        .gain_eff   (gain_eff),
        .lane_en    (dp_lane_en_o)
    );

    cfg_read_mux u_rmux (
        .addr       (reg_addr),
        .mode       (regs.mode),
        .swap_all   (regs.swap_all),
        .eq_ovr     (regs.eq_ovr),
        .hpd_force  (regs.hpd_force),
        .flip       (regs.flip),
        .lane_swap  (regs.lane_swap),
        .gain_ovr   (regs.gain_ovr),
        .gain_eff   (gain_eff),
        .dir_mode   (regs.dir_mode),
        .eq_up_eff  (eq_up_eff),
        .eq_dn_eff  (eq_dn_eff),
        .st_power   (st_power),
        .st_lanes   (st_lanes),
        .snoop_off  (regs.snoop_off),
        .aux_route  (regs.aux_route),
        .lane_dis   (regs.lane_dis),
        .pulse_full (pulse_full),
        .pulse_link (pulse_link),
        .cm_q       (cm_q),
        .usb_ctl    (regs.usb_ctl),
        .los_hyst   (regs.los_hyst),
        .los_vth    (regs.los_vth),
        .rdata      (reg_rdata)
    );

    assign mode_o      = regs.mode;
    assign flip_o      = regs.flip;
    assign swap_all_o  = regs.swap_all;
    assign hpd_force_o = regs.hpd_force;
    assign lane_swap_o = regs.lane_swap;
    assign dir_mode_o  = regs.dir_mode;
    assign gain_sel_o  = gain_eff;
    assign eq_ufp_o    = eq_up_eff;
    assign eq_dfp_o    = eq_dn_eff;
    assign aux_route_o = regs.aux_route;
    assign usb_ctl_o   = regs.usb_ctl;
    assign los_hyst_o  = regs.los_hyst;
    assign los_vth_o   = regs.los_vth;
endmodule

// File: rtl/cfg_regbank_chk.sv
// Checker: temporal properties of the register bank, bound to cfg_regbank.
// Observes ports and the storage/latch outputs; drives nothing.
module cfg_regbank_chk
    import cfg_regbank_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [REG_W-1:0]    reg_wdata,
    input logic                snoop_wr,
    input logic                pulse_full,
    input logic                pulse_link,
    input logic                eq_ovr,
    input logic                strap_done,
    input logic [PWR_W-1:0]    st_power,
    input logic [CNT_W-1:0]    st_lanes,
    input logic [1:0]          mode_o,
    input logic [DP_LANES-1:0] lane_swap_o,
    input logic [EQV_W-1:0]    eq_ufp_o,
    input logic [EQV_W-1:0]    eq_dfp_o,
    input logic [USB_W-1:0]    usb_ctl_o,
    input logic [LOS_W-1:0]    los_hyst_o,
    input logic [LOS_W-1:0]    los_vth_o
);
    logic decoded;
    logic eq_addr;

    always_comb begin
        decoded = (reg_addr == OFS_CORE) || (reg_addr == OFS_CHSWAP) || (reg_addr == OFS_GAIN) ||
                  (reg_addr == OFS_UP_B) || (reg_addr == OFS_UP_A) || (reg_addr == OFS_LINK) ||
                  (reg_addr == OFS_LANES) || (reg_addr == OFS_SRST) || (reg_addr == OFS_DN_B) ||
                  (reg_addr == OFS_DN_A) || (reg_addr == OFS_USB) || (reg_addr == OFS_LOS);
        eq_addr = (reg_addr == OFS_UP_B) || (reg_addr == OFS_UP_A) ||
                  (reg_addr == OFS_DN_B) || (reg_addr == OFS_DN_A);
    end

    assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !decoded && !pulse_full) |=>
            ($stable(mode_o) && $stable(lane_swap_o) && $stable(usb_ctl_o) &&
             $stable(los_hyst_o) && $stable(los_vth_o) && $stable(eq_ufp_o)));

    assert_eq_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && !eq_ovr && !pulse_full && reg_wr && eq_addr) |=>
            ($stable(eq_ufp_o) && $stable(eq_dfp_o)));

    assert_snoop_readonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_LINK && !snoop_wr) |=>
            ($stable(st_power) && $stable(st_lanes)));

    assert_full_trigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_SRST && reg_wdata[7] && !pulse_full) |=> pulse_full);

    assert_full_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_full |=> !pulse_full);

    assert_full_defaults_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_full |=> (mode_o == 2'd1 && los_hyst_o == 3'd4 && los_vth_o == 3'd3 &&
                        usb_ctl_o == 7'h04 && lane_swap_o == '0 && st_lanes == '0));

    assert_link_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_link |=> !pulse_link);

    assert_link_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_link |=> (st_power == '0 && st_lanes == '0));

    assert_mode_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CORE && mode_o[1] && !reg_wdata[1]) |=>
            (st_power == '0 && st_lanes == '0));
endmodule

bind cfg_regbank cfg_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .snoop_wr    (snoop_wr),
    .pulse_full  (pulse_full),
    .pulse_link  (pulse_link),
    .eq_ovr      (eq_ovr),
    .strap_done  (strap_done),
    .st_power    (st_power),
    .st_lanes    (st_lanes),
    .mode_o      (mode_o),
    .lane_swap_o (lane_swap_o),
    .eq_ufp_o    (eq_ufp_o),
    .eq_dfp_o    (eq_dfp_o),
    .usb_ctl_o   (usb_ctl_o),
    .los_hyst_o  (los_hyst_o),
    .los_vth_o   (los_vth_o)
);

// File: tb/sim_cfg_regbank.sv
// Directed bench for cfg_regbank: one task per scenario, each checking its
// own results at the ports. Inputs change on falling edges only.
module sim_cfg_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_rdata;
    logic [3:0]  strap_eq_up = 4'h5;
    logic [3:0]  strap_eq_dn = 4'hA;
    logic [1:0]  strap_gain_hi = 2'd3;
    logic [1:0]  strap_gain_lo = 2'd1;
    logic        snoop_wr = 1'b0;
    logic [1:0]  snoop_power = '0;
    logic [4:0]  snoop_lanes = '0;
    logic        compliance_in = 1'b0;
    logic [1:0]  mode_o;
    logic        flip_o, swap_all_o, hpd_force_o;
    logic [3:0]  lane_swap_o;
    logic [1:0]  dir_mode_o;
    logic [3:0]  gain_sel_o;
    logic [15:0] eq_ufp_o, eq_dfp_o;
    logic [3:0]  dp_lane_en_o;
    logic [1:0]  aux_route_o;
    logic [6:0]  usb_ctl_o;
    logic [2:0]  los_hyst_o, los_vth_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cfg_regbank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .strap_eq_up(strap_eq_up),
        .strap_eq_dn(strap_eq_dn), .strap_gain_hi(strap_gain_hi),
        .strap_gain_lo(strap_gain_lo), .snoop_wr(snoop_wr), .snoop_power(snoop_power),
        .snoop_lanes(snoop_lanes), .compliance_in(compliance_in), .mode_o(mode_o),
        .flip_o(flip_o), .swap_all_o(swap_all_o), .hpd_force_o(hpd_force_o),
        .lane_swap_o(lane_swap_o), .dir_mode_o(dir_mode_o), .gain_sel_o(gain_sel_o),
        .eq_ufp_o(eq_ufp_o), .eq_dfp_o(eq_dfp_o), .dp_lane_en_o(dp_lane_en_o),
        .aux_route_o(aux_route_o), .usb_ctl_o(usb_ctl_o), .los_hyst_o(los_hyst_o),
        .los_vth_o(los_vth_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] pw, input logic [4:0] cnt);
        snoop_power = pw;
        snoop_lanes = cnt;
        snoop_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        snoop_wr    = 1'b0;
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_defaults();
        hw_reset();
        rd_chk("R1 core", 8'h0A, 8'h01);
        rd_chk("R1 chswap", 8'h0B, 8'h00);
        rd_chk("R1 link", 8'h12, 8'h00);
        rd_chk("R1 lanes", 8'h13, 8'h00);
        rd_chk("R1 srst", 8'h1B, 8'h00);
        rd_chk("R1 usb", 8'h22, 8'h04);
        rd_chk("R1 los", 8'h23, 8'h23);
        rd_chk("R7 gain strap", 8'h0C, 8'h34);
        rd_chk("R5 up_b strap", 8'h10, 8'h55);
        rd_chk("R5 dn_a strap", 8'h21, 8'hAA);
        chk("R1 mode_o", {30'h0, mode_o}, 32'h1);
        chk("R9 lanes off at reset", {28'h0, dp_lane_en_o}, 32'h0);
    endtask

    task automatic t_strap_hold();
        hw_reset();
        strap_eq_up = 4'h0; strap_eq_dn = 4'h0; strap_gain_hi = 2'd0; strap_gain_lo = 2'd0;
        repeat (3) @(negedge clk);
        rd_chk("R4 up held", 8'h11, 8'h55);
        rd_chk("R4 dn held", 8'h20, 8'hAA);
        chk("R4 gain held", {28'h0, gain_sel_o}, 32'hD);
        chk("R4 eq_dfp held", {16'h0, eq_dfp_o}, 32'hAAAA);
        strap_eq_up = 4'h5; strap_eq_dn = 4'hA; strap_gain_hi = 2'd3; strap_gain_lo = 2'd1;
    endtask

    task automatic t_unmapped();
        hw_reset();
        wr(8'h0D, 8'hFF);
        wr(8'h1A, 8'hFF);
        wr(8'h24, 8'hFF);
        wr(8'hFF, 8'hFF);
        rd_chk("R2 read 0D", 8'h0D, 8'h00);
        rd_chk("R2 read 24", 8'h24, 8'h00);
        rd_chk("R2 read FF", 8'hFF, 8'h00);
        rd_chk("R2 core kept", 8'h0A, 8'h01);
        rd_chk("R2 chswap kept", 8'h0B, 8'h00);
        rd_chk("R2 los kept", 8'h23, 8'h23);
    endtask

    task automatic t_reserved();
        hw_reset();
        wr(8'h0A, 8'hFF); rd_chk("R3 core mask", 8'h0A, 8'h3F);
        wr(8'h0B, 8'hFF); rd_chk("R3 chswap mask", 8'h0B, 8'h0F);
        wr(8'h0C, 8'hFF); rd_chk("R3 gain mask", 8'h0C, 8'h7F);
        wr(8'h13, 8'hFF); rd_chk("R3 lanes mask", 8'h13, 8'hBF);
        wr(8'h23, 8'hFF); rd_chk("R3 los mask", 8'h23, 8'h3F);
        wr(8'h1B, 8'h3F); rd_chk("R3 srst low bits", 8'h1B, 8'h00);
    endtask

    task automatic t_eq();
        hw_reset();
        wr(8'h10, 8'h12);
        rd_chk("R5 write dropped", 8'h10, 8'h55);
        chk("R5 eq_ufp strap", {16'h0, eq_ufp_o}, 32'h5555);
        wr(8'h0A, 8'h11);
        rd_chk("R6 dropped write not stored", 8'h10, 8'h00);
        wr(8'h10, 8'h12);
        wr(8'h21, 8'h9C);
        rd_chk("R6 up_b stored", 8'h10, 8'h12);
        rd_chk("R6 dn_a stored", 8'h21, 8'h9C);
        rd_chk("R6 dn_b untouched", 8'h20, 8'h00);
        chk("R6 eq_ufp", {16'h0, eq_ufp_o}, 32'h1200);
        chk("R6 eq_dfp", {16'h0, eq_dfp_o}, 32'h009C);
        wr(8'h0A, 8'h01);
        rd_chk("R5 strap back", 8'h10, 8'h55);
    endtask

    task automatic t_gain();
        hw_reset();
        chk("R7 gain strap out", {28'h0, gain_sel_o}, 32'hD);
        wr(8'h0C, 8'h7B);
        rd_chk("R7 gain sw", 8'h0C, 8'h7B);
        chk("R7 gain_sel sw", {28'h0, gain_sel_o}, 32'hE);
        chk("R7 dir mode", {30'h0, dir_mode_o}, 32'h3);
        wr(8'h0C, 8'h28);
        rd_chk("R7 override off", 8'h0C, 8'h34);
        chk("R7 gain_sel strap again", {28'h0, gain_sel_o}, 32'hD);
        wr(8'h0C, 8'h40);
        rd_chk("R7 override on zero", 8'h0C, 8'h40);
    endtask

    task automatic t_snoop();
        hw_reset();
        snoop(2'd1, 5'd2);
        rd_chk("R8 status load", 8'h12, 8'h22);
        chk("R9 two lanes", {28'h0, dp_lane_en_o}, 32'h3);
        snoop(2'd1, 5'd1);
        chk("R9 one lane", {28'h0, dp_lane_en_o}, 32'h1);
        snoop(2'd1, 5'd3);
        chk("R9 illegal count", {28'h0, dp_lane_en_o}, 32'h0);
        snoop(2'd2, 5'd4);
        rd_chk("R8 power down status", 8'h12, 8'h44);
        chk("R9 power down", {28'h0, dp_lane_en_o}, 32'h0);
        snoop(2'd1, 5'd4);
        chk("R9 four lanes", {28'h0, dp_lane_en_o}, 32'hF);
        wr(8'h13, 8'h0F);
        chk("R9 disables ignored", {28'h0, dp_lane_en_o}, 32'hF);
        wr(8'h12, 8'hFF);
        rd_chk("R8 sw write ignored", 8'h12, 8'h24);
    endtask

    task automatic t_snoop_off();
        hw_reset();
        snoop(2'd1, 5'd4);
        wr(8'h13, 8'h85);
        rd_chk("R10 lanes reg", 8'h13, 8'h85);
        chk("R10 lane mask", {28'h0, dp_lane_en_o}, 32'hA);
        wr(8'h13, 8'hA0);
        chk("R10 aux route", {30'h0, aux_route_o}, 32'h2);
        chk("R10 all lanes on", {28'h0, dp_lane_en_o}, 32'hF);
    endtask

    task automatic t_full_reset();
        hw_reset();
        wr(8'h0A, 8'h17);
        wr(8'h23, 8'h00);
        wr(8'h22, 8'h00);
        snoop(2'd1, 5'd2);
        wr(8'h1B, 8'h80);
        rd_chk("R11 bit set one cycle", 8'h1B, 8'h80);
        chk("R11 mode before reset", {30'h0, mode_o}, 32'h3);
        @(negedge clk);
        rd_chk("R11 bit cleared", 8'h1B, 8'h00);
        rd_chk("R11 core default", 8'h0A, 8'h01);
        rd_chk("R11 los default", 8'h23, 8'h23);
        rd_chk("R11 usb default", 8'h22, 8'h04);
        rd_chk("R11 status cleared", 8'h12, 8'h00);
        rd_chk("R11 eq back to strap", 8'h10, 8'h55);
    endtask

    task automatic t_link_reset();
        hw_reset();
        wr(8'h0A, 8'h13);
        snoop(2'd1, 5'd4);
        wr(8'h1B, 8'h40);
        rd_chk("R12 bit set one cycle", 8'h1B, 8'h40);
        rd_chk("R12 status not yet cleared", 8'h12, 8'h24);
        @(negedge clk);
        rd_chk("R12 bit cleared", 8'h1B, 8'h00);
        rd_chk("R12 status cleared", 8'h12, 8'h00);
        rd_chk("R12 core kept", 8'h0A, 8'h13);
    endtask

    task automatic t_mode_drop();
        hw_reset();
        wr(8'h0A, 8'h03);
        snoop(2'd1, 5'd2);
        wr(8'h0A, 8'h02);
        rd_chk("R13 bit1 kept no clear", 8'h12, 8'h22);
        wr(8'h0A, 8'h01);
        rd_chk("R13 drop clears", 8'h12, 8'h00);
    endtask

    task automatic t_compliance();
        hw_reset();
        compliance_in = 1'b1;
        @(negedge clk);
        rd_chk("R14 status follows", 8'h22, 8'h84);
        wr(8'h22, 8'h00);
        rd_chk("R14 bit7 not writable", 8'h22, 8'h80);
        chk("R14 usb_ctl written", {25'h0, usb_ctl_o}, 32'h0);
        compliance_in = 1'b0;
        @(negedge clk);
        rd_chk("R14 status drops", 8'h22, 8'h00);
    endtask

    initial begin
        t_defaults();
        t_strap_hold();
        t_unmapped();
        t_reserved();
        t_eq();
        t_gain();
        t_snoop();
        t_snoop_off();
        t_full_reset();
        t_link_reset();
        t_mode_drop();
        t_compliance();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule